// File: doc/BRIEF.md
# SMBus Packet Error Code Unit

This block keeps the running packet error code for one SMBus port. A byte-level front end strobes every byte seen on the bus into it: each address byte with its direction bit, the command byte and the data bytes, in the order they appear on the wire. The code is an 8-bit CRC with generator x^8 + x^2 + x + 1, taken most-significant bit first from a zero start value, with no reflection and no final inversion. One full byte is folded into the register per clock, so bytes may arrive on back-to-back cycles.

Transaction framing comes from START and STOP strobes. Only a START that opens a transaction clears the register. A repeated START inside an open transaction leaves it alone, so the read address after a repeated START is covered by the same code. When the port transmits, `pec_o` holds the byte to append after the last data byte. When it receives, the front end marks the final byte (the received code) with `last_i`. The unit then passes that byte through the CRC and raises a one-cycle result pulse, with an error flag if the remainder is not zero, so the target can NACK that byte. The error flag stays set until the next opening START. Packet error checking is optional for each transaction: with `pec_en_i` low, bytes are ignored.

Top module: `smb_pec_unit`

## Requirements
- R1: After reset, `pec_o` is 0x00, `chk_vld_o` is 0 and `chk_err_o` is 0.
- R2: Each absorbed byte updates the code as CRC-8 with polynomial 0x07, MSB first, with no reflection and no final XOR. From zero, byte 0x01 gives 0x07, byte 0xFF gives 0xF3, and the ASCII string "123456789" gives 0xF4.
- R3: A byte strobed on a clock edge is reflected in `pec_o` right after that edge. Bytes on consecutive cycles are all absorbed.
- R4: A START while no transaction is open sets the code to 0x00.
- R5: A START while a transaction is open (a repeated START, before any STOP) leaves the code unchanged. Later bytes keep accumulating onto it.
- R6: A STOP closes the transaction, so the next START clears again.
- R7: With `pec_en_i` low, strobed bytes do not change `pec_o` and never produce a check result.
- R8: A byte with `byte_vld_i`, `last_i`, `rx_mode_i` and `pec_en_i` all high causes `chk_vld_o` to be high for exactly the next cycle. If the remainder after absorbing that byte is nonzero, `chk_err_o` is 1 from that cycle on.
- R9: When the final received byte equals the code of the preceding bytes, `chk_err_o` stays 0 and `pec_o` reads 0x00 after it.
- R10: `chk_err_o`, once set, holds through STOP and clears only on a START that opens a new transaction.
- R11: A byte strobed in the same cycle as an opening START is absorbed onto the cleared value of zero.
- R12: With `rx_mode_i` low, a byte marked `last_i` is absorbed but produces no check result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pec_en_i | input | 1 | Packet error checking enabled for this transaction |
| rx_mode_i | input | 1 | 1: port receives and checks the final byte; 0: port transmits |
| start_i | input | 1 | One-cycle strobe for a START or repeated START condition |
| stop_i | input | 1 | One-cycle strobe for a STOP condition |
| byte_vld_i | input | 1 | Byte strobe for `byte_i` |
| byte_i | input | 8 | Bus byte (address with R/W, command or data) |
| last_i | input | 1 | Marks the final byte of the transaction |
| pec_o | output | 8 | Running code; in transmit mode, the byte to append |
| chk_vld_o | output | 1 | One-cycle pulse: result of the final-byte check |
| chk_err_o | output | 1 | Final-byte check failed (held until the next opening START) |

## Verification
The CRC register drives `pec_o` directly, so a wrong polynomial, bit order or start value shows up at the port one cycle after the first byte. A wrong framing state is different. If the transaction-open flag is stuck or mis-set, nothing is visible until a START arrives: the code is either cleared by a repeated START or not cleared by an opening one, and `pec_o` reads wrong in the cycle after that START. A fault in the check path shows up only at a final receive byte. It appears as a missing or doubled `chk_vld_o` pulse, or as a `chk_err_o` value that disagrees with the zero-remainder rule in that same cycle. The stimulus therefore mixes back-to-back bytes, repeated STARTs, good and corrupted final bytes, and disabled transactions.

// File: rtl/smb_pec_pkg.sv
// Package: shared constants and types for the SMBus packet error code unit.
// Assumes byte-wide bus transfers and an 8-bit check code.
package smb_pec_pkg;
    localparam int          PEC_W     = 8;
    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  PEC_POLY  = 8'h07;
    localparam logic [7:0]  PEC_INIT  = 8'h00;

    // Result of the final-byte check as registered for the ports.
    typedef struct packed {
        logic vld;
        logic err;
    } pec_chk_t;
endpackage

// File: rtl/smb_pec_byte_step.sv
// Module: combinational CRC update for one whole input word.
// Unrolls one shift-and-conditional-XOR stage per input bit, MSB first.
// Assumes no reflection; the polynomial excludes the implicit top term.
module smb_pec_byte_step #(
    parameter int              CRC_W  = 8,
    parameter int              DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY  = 8'h07
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    localparam int STAGES = DATA_W + 1;

    logic [CRC_W-1:0] stage [STAGES];

    assign stage[0] = crc_i;

    // One stage per data bit, highest data bit consumed first.
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            logic fb;
            assign fb           = stage[b][CRC_W-1] ^ data_i[DATA_W-1-b];
            assign stage[b+1]   = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    endgenerate

    assign crc_o = stage[DATA_W];
endmodule

// File: rtl/smb_pec_txn_track.sv
// Module: tracks whether an SMBus transaction is open.
// An opening START produces a clear pulse; a repeated START does not.
// Assumes START and STOP strobes are single-cycle; STOP wins if both coincide.
module smb_pec_txn_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic clear_o,
    output logic open_o
);
    logic open_q;

    // Clear only when a START arrives with no transaction in progress.
    assign clear_o = start_i && !open_q;
    assign open_o  = open_q;

    // Open on START, close on STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)       open_q <= 1'b0;
        else if (stop_i)  open_q <= 1'b0;
        else if (start_i) open_q <= 1'b1;
    end
endmodule

// File: rtl/smb_pec_crc_reg.sv
// Module: the running check-code register.
// A clear loads the start value before any same-cycle byte is folded in.
// Assumes absorb is already gated by the enable.
module smb_pec_crc_reg
    import smb_pec_pkg::*;
#(
    parameter int               CRC_W  = PEC_W,
    parameter int               DATA_W = BYTE_W,
    parameter logic [CRC_W-1:0] POLY   = PEC_POLY,
    parameter logic [CRC_W-1:0] INIT   = PEC_INIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              absorb_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_q_o,
    output logic [CRC_W-1:0]  crc_d_o
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] stepped;

    // Select the value the incoming byte is folded onto.
    always_comb begin
        base = clear_i ? INIT : crc_q;
    end

    smb_pec_byte_step #(
        .CRC_W (CRC_W),
        .DATA_W(DATA_W),
        .POLY  (POLY)
    ) step_i (
        .crc_i (base),
        .data_i(data_i),
        .crc_o (stepped)
    );

    // Next register value: stepped when absorbing, else the base.
    always_comb begin
        crc_d_o = absorb_i ? stepped : base;
    end

    // Hold the running code.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d_o;
    end

    assign crc_q_o = crc_q;
endmodule

// File: rtl/smb_pec_rx_check.sv
// Module: registers the final-byte check of a received transaction.
// The pulse follows the final byte by one cycle; the error is sticky
// until the next opening START. Assumes remainder_i is the post-byte code.
module smb_pec_rx_check
    import smb_pec_pkg::*;
#(
    parameter int CRC_W = PEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             final_i,
    input  logic [CRC_W-1:0] remainder_i,
    output pec_chk_t         chk_o
);
    pec_chk_t chk_q;
    logic     bad;

    // A nonzero remainder after the received code means a mismatch.
    assign bad = final_i && (remainder_i != '0);

    // Pulse on every checked byte; error set on mismatch, cleared on opening START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_q <= '0;
        end else begin
            chk_q.vld <= final_i;
            if (bad)          chk_q.err <= 1'b1;
            else if (clear_i) chk_q.err <= 1'b0;
        end
    end

    assign chk_o = chk_q;
endmodule

// File: rtl/smb_pec_unit.sv
// Module: top of the SMBus packet error code unit.
// Frames transactions with START/STOP, folds each enabled byte into the
// running CRC-8 and checks the final received byte for a zero remainder.
// Assumes one byte strobe per cycle at most and synchronous inputs.
module smb_pec_unit
    import smb_pec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pec_en_i,
    input  logic              rx_mode_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              last_i,
    output logic [PEC_W-1:0]  pec_o,
    output logic              chk_vld_o,
    output logic              chk_err_o
);
    logic             clear;
    logic             txn_open;
    logic             absorb;
    logic             final_rx;
    logic [PEC_W-1:0] crc_q;
    logic [PEC_W-1:0] crc_d;
    pec_chk_t         chk;

    smb_pec_txn_track track_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .stop_i (stop_i),
        .clear_o(clear),
        .open_o (txn_open)
    );

    // Qualify byte strobes with the per-transaction enable and mode.
    always_comb begin
        absorb   = byte_vld_i && pec_en_i;
        final_rx = absorb && last_i && rx_mode_i;
    end

    smb_pec_crc_reg #(
        .CRC_W (PEC_W),
        .DATA_W(BYTE_W),
        .POLY  (PEC_POLY),
        .INIT  (PEC_INIT)
    ) crc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .absorb_i(absorb),
        .data_i  (byte_i),
        .crc_q_o (crc_q),
        .crc_d_o (crc_d)
    );

    smb_pec_rx_check #(
        .CRC_W(PEC_W)
    ) chk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .final_i    (final_rx),
        .remainder_i(crc_d),
        .chk_o      (chk)
    );

    assign pec_o     = crc_q;
    assign chk_vld_o = chk.vld;
    assign chk_err_o = chk.err;
endmodule

// File: rtl/smb_pec_unit_chk.sv
// Module: temporal checks on the packet error code unit, bound to the top.
module smb_pec_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pec_en_i,
    input logic       rx_mode_i,
    input logic       start_i,
    input logic       byte_vld_i,
    input logic       last_i,
    input logic [7:0] pec_o,
    input logic       chk_vld_o,
    input logic       chk_err_o,
    input logic       txn_open
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pec_o == 8'h00 && !chk_vld_o && !chk_err_o));

    assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pec_en_i && !start_i) |=> $stable(pec_o));

    assert_repeat_start_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && txn_open && !byte_vld_i) |=> $stable(pec_o));

    assert_open_start_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !txn_open && !byte_vld_i) |=> (pec_o == 8'h00));

    assert_check_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && pec_en_i && last_i && rx_mode_i) |=> chk_vld_o);

    assert_check_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld_o |-> $past(byte_vld_i && pec_en_i && last_i && rx_mode_i));

    assert_bad_remainder_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_o && pec_o != 8'h00) |-> chk_err_o);

    assert_good_remainder_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_o && !chk_err_o) |-> (pec_o == 8'h00));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chk_err_o) |-> $past(start_i && !txn_open));
endmodule

bind smb_pec_unit smb_pec_unit_chk chk_bind_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pec_en_i  (pec_en_i),
    .rx_mode_i (rx_mode_i),
    .start_i   (start_i),
    .byte_vld_i(byte_vld_i),
    .last_i    (last_i),
    .pec_o     (pec_o),
    .chk_vld_o (chk_vld_o),
    .chk_err_o (chk_err_o),
    .txn_open  (txn_open)
);

// File: tb/smb_pec_unit_tb.sv
// Bench for the packet error code unit: table walk, then directed cases.
module smb_pec_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pec_en_i = 1'b0;
    logic       rx_mode_i = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       last_i = 1'b0;
    logic [7:0] pec_o;
    logic       chk_vld_o;
    logic       chk_err_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // ASCII "123456789"; its code from zero is 0xF4.
    localparam int         N_MSG = 9;
    localparam logic [7:0] MSG [N_MSG] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35,
                                            8'h36, 8'h37, 8'h38, 8'h39};

    always #10 clk = ~clk;

    smb_pec_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pec_en_i  (pec_en_i),
        .rx_mode_i (rx_mode_i),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .byte_vld_i(byte_vld_i),
        .byte_i    (byte_i),
        .last_i    (last_i),
        .pec_o     (pec_o),
        .chk_vld_o (chk_vld_o),
        .chk_err_o (chk_err_o)
    );

    // Reference: bit-serial division by x^8+x^2+x+1, MSB first.
    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic top = r[7] ^ d[i];
            r = {r[6:0], 1'b0};
            if (top) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start_i = 0; stop_i = 0; byte_vld_i = 0; last_i = 0;
    endtask

    // Pulse a framing strobe for one cycle; returns at the following negedge.
    task automatic do_start();
        @(negedge clk); idle_inputs(); start_i = 1;
        @(negedge clk); idle_inputs();
    endtask

    task automatic do_stop();
        @(negedge clk); idle_inputs(); stop_i = 1;
        @(negedge clk); idle_inputs();
    endtask

    task automatic do_byte(input logic [7:0] b, input logic lst);
        @(negedge clk); idle_inputs(); byte_vld_i = 1; byte_i = b; last_i = lst;
        @(negedge clk); idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 pec", pec_o, 8'h00);
        check("R1 vld", {7'b0, chk_vld_o}, 8'h00);
        check("R1 err", {7'b0, chk_err_o}, 8'h00);

        pec_en_i = 1; rx_mode_i = 0;

        // R2/R3 table walk, bytes back to back
        do_start();
        exp = 8'h00;
        for (int k = 0; k < N_MSG; k++) begin
            byte_vld_i = 1; byte_i = MSG[k];
            exp = ref_crc(exp, MSG[k]);
            @(negedge clk);
            check($sformatf("R3 step %0d", k), pec_o, exp);
        end
        idle_inputs();
        check("R2 check string", pec_o, 8'hF4);
        do_stop();

        // R4 opening START clears
        do_start();
        check("R4 cleared", pec_o, 8'h00);
        do_byte(8'h01, 0);
        check("R2 byte 01", pec_o, 8'h07);
        do_stop();
        do_start();
        do_byte(8'hFF, 0);
        check("R2 byte FF", pec_o, 8'hF3);

        // R6 STOP then START clears again
        do_stop();
        do_start();
        check("R6 clear after stop", pec_o, 8'h00);

        // R5 repeated START keeps accumulating
        do_byte(8'hA6, 0);
        do_byte(8'h10, 0);
        exp = ref_crc(ref_crc(8'h00, 8'hA6), 8'h10);
        do_start();
        check("R5 repeated start hold", pec_o, exp);
        do_byte(8'hA7, 0);
        exp = ref_crc(exp, 8'hA7);
        check("R5 after read addr", pec_o, exp);

        // R9 correct received code
        rx_mode_i = 1;
        do_byte(8'h5C, 0);
        exp = ref_crc(exp, 8'h5C);
        @(negedge clk); byte_vld_i = 1; byte_i = exp; last_i = 1;
        @(negedge clk); idle_inputs();
        check("R8 pulse on good", {7'b0, chk_vld_o}, 8'h01);
        check("R9 no error", {7'b0, chk_err_o}, 8'h00);
        check("R9 zero remainder", pec_o, 8'h00);
        @(negedge clk);
        check("R8 pulse one cycle", {7'b0, chk_vld_o}, 8'h00);
        do_stop();

        // R8 wrong received code, R10 sticky error
        do_start();
        do_byte(8'hA7, 0);
        exp = ref_crc(8'h00, 8'hA7);
        do_byte(8'h3E, 0);
        exp = ref_crc(exp, 8'h3E);
        @(negedge clk); byte_vld_i = 1; byte_i = exp ^ 8'h01; last_i = 1;
        @(negedge clk); idle_inputs();
        check("R8 pulse on bad", {7'b0, chk_vld_o}, 8'h01);
        check("R8 error set", {7'b0, chk_err_o}, 8'h01);
        @(negedge clk);
        check("R10 error held", {7'b0, chk_err_o}, 8'h01);
        do_stop();
        check("R10 held after stop", {7'b0, chk_err_o}, 8'h01);
        do_start();
        check("R10 cleared on open start", {7'b0, chk_err_o}, 8'h00);

        // R7 disabled transaction ignores bytes
        do_byte(8'h42, 0);
        exp = ref_crc(8'h00, 8'h42);
        pec_en_i = 0;
        do_byte(8'h99, 0);
        check("R7 byte ignored", pec_o, exp);
        @(negedge clk); byte_vld_i = 1; byte_i = 8'h13; last_i = 1;
        @(negedge clk); idle_inputs();
        check("R7 no check pulse", {7'b0, chk_vld_o}, 8'h00);
        check("R7 code unchanged", pec_o, exp);
        pec_en_i = 1;
        do_stop();

        // R11 START and byte in the same cycle
        @(negedge clk); idle_inputs(); start_i = 1; byte_vld_i = 1; byte_i = 8'h80;
        @(negedge clk); idle_inputs();
        check("R11 absorbed on zero", pec_o, 8'h89);

        // R12 transmit-mode last byte: absorbed, no check
        rx_mode_i = 0;
        do_byte(8'h55, 1);
        check("R12 no check in tx", {7'b0, chk_vld_o}, 8'h00);
        check("R12 byte absorbed", pec_o, ref_crc(8'h89, 8'h55));
        do_stop();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule